// File: doc/BRIEF.md
# NAND Command Interface Decoder

This block is the device-side front end of a NAND flash die. It watches the command-latch, address-latch and write-strobe pins, captures each byte on the rising write strobe, and recognises the legal multi-byte command sequences: page read, page program with streamed data, single and two-plane block erase, status read, identification read and reset. Sequences that go wrong part way through are silently dropped.

A recognised operation appears on a one-cycle request to a back end. The request carries the operation kind, a 12-bit column, an 18-bit page row and, for a two-plane erase, the second row. The back end answers with a one-cycle done pulse and a pass/fail flag. While an operation is outstanding, the block pulls the ready/busy line low through an open-drain enable. Falling read-strobe cycles return either the status byte or the identification bytes on the output bus. The block also enforces write protection and the per-page partial-program budget.

Top module: `nand_cmd_decoder`

## Requirements
- R1: After reset, the busy line is released (rbLow = 0), no request is issued, and a status read returns 8'hC0 while wpN is high.
- R2: Command 00h, five address bytes and then 30h issue one request with opKind = 1 (read). rbLow then stays 1 until beDone.
- R3: Column byte 1 gives column bits 7:0 and bits 3:0 of column byte 2 give bits 11:8. The three row bytes give row bits 7:0, 15:8 and 17:16 (the low two bits). All higher bits are dropped.
- R4: After a completed read, five address bytes followed by 30h with no new 00h issue another read. Any other command byte disarms this shortcut.
- R5: 80h, five address bytes, any number of data bytes and then 10h issue opKind = 2 (program). Each data byte is forwarded in order on wrValid/wrByte.
- R6: 60h, three row bytes and D0h issue opKind = 3 (erase) with opDual = 0. When a second 60h and row group comes before D0h, opDual = 1, opRow holds the second row and opRowAlt holds the first row.
- R7: 70h makes read cycles return the status byte: bit 7 = wpN level, bit 6 = ready, bit 0 = fail of the last program or erase. 70h is accepted while busy or in the middle of a sequence and does not disturb it.
- R8: 90h and one address byte make successive read cycles return ECh, DCh, 10h, 95h. The index advances on each rising read strobe.
- R9: FFh is accepted in any state. It pulses opAbort, releases rbLow and returns the decoder to idle.
- R10: While busy, every byte except 70h and FFh is ignored.
- R11: With wpN low, a program or erase confirm issues no request, leaves rbLow released and sets status bit 0.
- R12: On one page, at most four programs to the main area (column bit 11 = 0) and four to the spare area (bit 11 = 1) are accepted. A further one issues no request and sets the fail bit. An erase restores the budget.
- R13: An unexpected command byte, or an address or data byte out of place, discards a partial sequence without issuing a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on it |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Active-low chip enable; strobes are ignored when high |
| cleIn | input | 1 | Command latch enable |
| aleIn | input | 1 | Address latch enable |
| weN | input | 1 | Active-low write strobe; byte captured on its rising edge |
| reN | input | 1 | Active-low read strobe; read index advances on its rising edge |
| wpN | input | 1 | Active-low write protect |
| ioIn | input | 8 | Byte bus into the device |
| ioOut | output | 8 | Status or identification byte for read cycles |
| rbLow | output | 1 | Open-drain pull-down enable for the ready/busy line |
| beDone | input | 1 | Back end finished the outstanding operation |
| beFail | input | 1 | Result with beDone: 1 = failed |
| opValid | output | 1 | One-cycle operation request |
| opKind | output | 2 | 1 read, 2 program, 3 erase |
| opCol | output | 12 | Assembled column address |
| opRow | output | 18 | Assembled page row address |
| opRowAlt | output | 18 | First row of a two-plane erase, else zero |
| opDual | output | 1 | Two-plane erase request |
| opAbort | output | 1 | One-cycle abort pulse on reset command |
| wrValid | output | 1 | Program data byte strobe |
| wrByte | output | 8 | Program data byte |

## Verification
The bench targets the read shortcut without 00h. A decoder that ignored the armed state would miss the second read, and one that kept it armed after a malformed sequence would issue a stray read. The bench sends status polls in the middle of a program sequence and while busy, to catch a decoder that treats 70h as a sequence breaker or loses the busy state. It gives a fifth main-area program to one page and then a spare-area program, to catch a single shared counter or a missing limit. It sends a two-plane erase, to catch the two rows swapped or dropped. It issues FFh both mid-sequence and while busy, to expose a decoder that leaves rbLow held or resumes the old sequence.

// File: rtl/nandif_pkg.sv
package nandif_pkg;

  localparam logic [7:0] CMD_READ0   = 8'h00;
  localparam logic [7:0] CMD_READ1   = 8'h30;
  localparam logic [7:0] CMD_PROG0   = 8'h80;
  localparam logic [7:0] CMD_PROG1   = 8'h10;
  localparam logic [7:0] CMD_ERASE0  = 8'h60;
  localparam logic [7:0] CMD_ERASE1  = 8'hD0;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_RESET   = 8'hFF;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } opKind_t;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_IDENT  = 2'd2
  } rdMode_t;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic    addrClrFull;
    logic    addrClrRow;
    logic    addrLoad;
    logic    saveAlt;
    logic    dataPass;
    logic    issue;
    opKind_t issueKind;
    logic    issueDual;
    logic    reject;
    logic    abort;
    logic    setStatus;
    logic    setIdent;
    logic    setNone;
    logic    rdAdvance;
  } ctlStrobe_t;

endpackage

// File: rtl/nandif_ctrl.sv
module nandif_ctrl
  import nandif_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cleIn,
  input  logic       aleIn,
  input  logic       weN,
  input  logic       reN,
  input  logic       wpN,
  input  logic [7:0] ioIn,
  input  logic       addrLast,
  input  logic       progOk,
  input  logic       busy,
  output ctlStrobe_t stb
);

  typedef enum logic [2:0] {
    S_IDLE, S_RADDR, S_RCONF, S_PADDR, S_PDATA, S_EADDR, S_ECONF, S_IDADDR
  } state_t;

  state_t state, nextState;
  logic   weQ, reQ;
  logic   readArmed, nextArmed;
  logic   second, nextSecond;
  logic   weRise, reRise;
  logic   cmdHit, addrHit, dataHit, anyHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weQ       <= 1'b1;
      reQ       <= 1'b1;
      state     <= S_IDLE;
      readArmed <= 1'b0;
      second    <= 1'b0;
    end else begin
      weQ       <= weN;
      reQ       <= reN;
      state     <= nextState;
      readArmed <= nextArmed;
      second    <= nextSecond;
    end
  end

  assign weRise  = !weQ && weN && !ceN;
  assign reRise  = !reQ && reN && !ceN;
  assign cmdHit  = weRise && cleIn && !aleIn;
  assign addrHit = weRise && aleIn && !cleIn;
  assign dataHit = weRise && !cleIn && !aleIn;
  assign anyHit  = cmdHit || addrHit || dataHit;

  always_comb begin
    stb           = '0;
    stb.issueKind = OP_NONE;
    stb.rdAdvance = reRise;
    nextState     = state;
    nextArmed     = readArmed;
    nextSecond    = second;

    if (cmdHit && ioIn == CMD_RESET) begin
      stb.abort = 1'b1;
      nextState = S_IDLE;
      nextArmed = 1'b0;
    end else if (cmdHit && ioIn == CMD_STATUS) begin
      stb.setStatus = 1'b1;
    end else if (!busy) begin
      if (cmdHit || dataHit) nextArmed = 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmdHit) begin
            unique case (ioIn)
              CMD_READ0: begin
                stb.addrClrFull = 1'b1;
                stb.setNone     = 1'b1;
                nextState       = S_RADDR;
              end
              CMD_PROG0: begin
                stb.addrClrFull = 1'b1;
                nextState       = S_PADDR;
              end
              CMD_ERASE0: begin
                stb.addrClrRow = 1'b1;
                nextSecond     = 1'b0;
                nextState      = S_EADDR;
              end
              CMD_IDENT: nextState = S_IDADDR;
              default:   nextState = S_IDLE;
            endcase
          end else if (addrHit && readArmed) begin
            stb.addrClrFull = 1'b1;
            stb.addrLoad    = 1'b1;
            nextState       = S_RADDR;
          end
        end
        S_RADDR: begin
          if (addrHit) begin
            stb.addrLoad = 1'b1;
            if (addrLast) nextState = S_RCONF;
          end else if (anyHit) begin
            nextState = S_IDLE;
          end
        end
        S_RCONF: begin
          if (cmdHit && ioIn == CMD_READ1) begin
            stb.issue     = 1'b1;
            stb.issueKind = OP_READ;
            nextArmed     = 1'b1;
            nextState     = S_IDLE;
          end else if (anyHit) begin
            nextArmed = 1'b0;
            nextState = S_IDLE;
          end
        end
        S_PADDR: begin
          if (addrHit) begin
            stb.addrLoad = 1'b1;
            if (addrLast) nextState = S_PDATA;
          end else if (anyHit) begin
            nextState = S_IDLE;
          end
        end
        S_PDATA: begin
          if (dataHit) begin
            stb.dataPass = 1'b1;
          end else if (cmdHit && ioIn == CMD_PROG1) begin
            if (progOk) begin
              stb.issue     = 1'b1;
              stb.issueKind = OP_PROG;
            end else begin
              stb.reject = 1'b1;
            end
            nextState = S_IDLE;
          end else if (anyHit) begin
            nextState = S_IDLE;
          end
        end
        S_EADDR: begin
          if (addrHit) begin
            stb.addrLoad = 1'b1;
            if (addrLast) nextState = S_ECONF;
          end else if (anyHit) begin
            nextState = S_IDLE;
          end
        end
        S_ECONF: begin
          if (cmdHit && ioIn == CMD_ERASE1) begin
            if (wpN) begin
              stb.issue     = 1'b1;
              stb.issueKind = OP_ERASE;
              stb.issueDual = second;
            end else begin
              stb.reject = 1'b1;
            end
            nextState = S_IDLE;
          end else if (cmdHit && ioIn == CMD_ERASE0 && !second) begin
            stb.saveAlt    = 1'b1;
            stb.addrClrRow = 1'b1;
            nextSecond     = 1'b1;
            nextState      = S_EADDR;
          end else if (anyHit) begin
            nextState = S_IDLE;
          end
        end
        S_IDADDR: begin
          if (addrHit) begin
            stb.setIdent = 1'b1;
            nextState    = S_IDLE;
          end else if (anyHit) begin
            nextState = S_IDLE;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nandif_dpath.sv
module nandif_dpath
  import nandif_pkg::*;
#(
  parameter int COL_W      = 12,
  parameter int ROW_W      = 18,
  parameter int COL_CYC    = 2,
  parameter int ROW_CYC    = 3,
  parameter int PART_LIMIT = 4,
  parameter logic [7:0] ID_MAKER = 8'hEC,
  parameter logic [7:0] ID_DEV   = 8'hDC,
  parameter logic [7:0] ID_B3    = 8'h10,
  parameter logic [7:0] ID_B4    = 8'h95
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       stb,
  input  logic             wpN,
  input  logic [7:0]       ioIn,
  input  logic             beDone,
  input  logic             beFail,
  output logic             addrLast,
  output logic             progOk,
  output logic             busy,
  output logic [7:0]       ioOut,
  output logic             opValid,
  output opKind_t          opKind,
  output logic [COL_W-1:0] opCol,
  output logic [ROW_W-1:0] opRow,
  output logic [ROW_W-1:0] opRowAlt,
  output logic             opDual,
  output logic             opAbort,
  output logic             wrValid,
  output logic [7:0]       wrByte
);

  localparam int ADDR_CYC = COL_CYC + ROW_CYC;
  localparam int IDX_W    = $clog2(ADDR_CYC + 1);
  localparam int FLAT_W   = ADDR_CYC * 8;
  localparam int CNT_W    = $clog2(PART_LIMIT + 1);

  logic [IDX_W-1:0]  addrIdx, baseIdx;
  logic [FLAT_W-1:0] addrFlat;
  logic [COL_W-1:0]  colAddr;
  logic [ROW_W-1:0]  rowAddr, rowAlt, lastRow;
  logic              lastValid, failFlag, curWrites, sameRow, spareSel;
  logic [CNT_W-1:0]  mainCnt, spareCnt;
  rdMode_t           rdMode;
  logic [1:0]        idIdx;
  logic              unusedAddr;

  assign colAddr    = addrFlat[COL_W-1:0];
  assign rowAddr    = addrFlat[COL_CYC*8 +: ROW_W];
  assign unusedAddr = ^addrFlat;
  assign addrLast   = (addrIdx == IDX_W'(ADDR_CYC - 1));
  assign spareSel   = colAddr[COL_W-1];
  assign sameRow    = lastValid && (lastRow == rowAddr);

  always_comb begin
    if (stb.addrClrFull)     baseIdx = '0;
    else if (stb.addrClrRow) baseIdx = IDX_W'(COL_CYC);
    else                     baseIdx = addrIdx;
  end

  always_comb begin
    if (!wpN)          progOk = 1'b0;
    else if (!sameRow) progOk = 1'b1;
    else if (spareSel) progOk = (spareCnt < CNT_W'(PART_LIMIT));
    else               progOk = (mainCnt < CNT_W'(PART_LIMIT));
  end

  // address assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrIdx  <= '0;
      addrFlat <= '0;
      rowAlt   <= '0;
    end else begin
      if (stb.saveAlt) rowAlt <= rowAddr;
      if (stb.addrLoad && (baseIdx < IDX_W'(ADDR_CYC))) begin
        addrFlat[{baseIdx, 3'b000} +: 8] <= ioIn;
        addrIdx <= baseIdx + 1'b1;
      end else if (stb.addrClrFull || stb.addrClrRow) begin
        addrIdx <= baseIdx;
      end
    end
  end

  // request, busy and status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opValid   <= 1'b0;
      opKind    <= OP_NONE;
      opCol     <= '0;
      opRow     <= '0;
      opRowAlt  <= '0;
      opDual    <= 1'b0;
      opAbort   <= 1'b0;
      busy      <= 1'b0;
      failFlag  <= 1'b0;
      curWrites <= 1'b0;
      wrValid   <= 1'b0;
      wrByte    <= '0;
    end else begin
      opValid <= stb.issue;
      opAbort <= stb.abort;
      wrValid <= stb.dataPass;
      if (stb.dataPass) wrByte <= ioIn;
      if (stb.issue) begin
        opKind    <= stb.issueKind;
        opCol     <= colAddr;
        opRow     <= rowAddr;
        opRowAlt  <= stb.issueDual ? rowAlt : '0;
        opDual    <= stb.issueDual;
        busy      <= 1'b1;
        curWrites <= (stb.issueKind != OP_READ);
      end
      if (stb.reject) failFlag <= 1'b1;
      if (stb.abort) begin
        busy <= 1'b0;
      end else if (beDone && busy) begin
        busy <= 1'b0;
        if (curWrites) failFlag <= beFail;
      end
    end
  end

  // partial program budget for the most recently programmed page
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastValid <= 1'b0;
      lastRow   <= '0;
      mainCnt   <= '0;
      spareCnt  <= '0;
    end else if (stb.issue && stb.issueKind == OP_ERASE) begin
      lastValid <= 1'b0;
    end else if (stb.issue && stb.issueKind == OP_PROG) begin
      if (!sameRow) begin
        lastValid <= 1'b1;
        lastRow   <= rowAddr;
        mainCnt   <= spareSel ? CNT_W'(0) : CNT_W'(1);
        spareCnt  <= spareSel ? CNT_W'(1) : CNT_W'(0);
      end else if (spareSel) begin
        spareCnt <= spareCnt + 1'b1;
      end else begin
        mainCnt <= mainCnt + 1'b1;
      end
    end
  end

  // read-out mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdMode <= RD_NONE;
      idIdx  <= '0;
    end else begin
      if (stb.setStatus)      rdMode <= RD_STATUS;
      else if (stb.setIdent)  rdMode <= RD_IDENT;
      else if (stb.setNone)   rdMode <= RD_NONE;
      if (stb.setIdent)       idIdx <= '0;
      else if (stb.rdAdvance && rdMode == RD_IDENT) idIdx <= idIdx + 1'b1;
    end
  end

  always_comb begin
    unique case (rdMode)
      RD_STATUS: ioOut = {wpN, !busy, 5'b0, failFlag};
      RD_IDENT: begin
        unique case (idIdx)
          2'd0:    ioOut = ID_MAKER;
          2'd1:    ioOut = ID_DEV;
          2'd2:    ioOut = ID_B3;
          default: ioOut = ID_B4;
        endcase
      end
      default: ioOut = 8'h00;
    endcase
  end

endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
  import nandif_pkg::*;
#(
  parameter int COL_W      = 12,
  parameter int ROW_W      = 18,
  parameter int PART_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             cleIn,
  input  logic             aleIn,
  input  logic             weN,
  input  logic             reN,
  input  logic             wpN,
  input  logic [7:0]       ioIn,
  output logic [7:0]       ioOut,
  output logic             rbLow,
  input  logic             beDone,
  input  logic             beFail,
  output logic             opValid,
  output logic [1:0]       opKind,
  output logic [COL_W-1:0] opCol,
  output logic [ROW_W-1:0] opRow,
  output logic [ROW_W-1:0] opRowAlt,
  output logic             opDual,
  output logic             opAbort,
  output logic             wrValid,
  output logic [7:0]       wrByte
);

  localparam int COL_CYC = (COL_W + 7) / 8;
  localparam int ROW_CYC = (ROW_W + 7) / 8;

  ctlStrobe_t stb;
  logic       addrLast, progOk, busy;
  opKind_t    kindInt;

  nandif_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cleIn(cleIn), .aleIn(aleIn),
    .weN(weN), .reN(reN), .wpN(wpN), .ioIn(ioIn),
    .addrLast(addrLast), .progOk(progOk), .busy(busy), .stb(stb)
  );

  nandif_dpath #(
    .COL_W(COL_W), .ROW_W(ROW_W), .COL_CYC(COL_CYC), .ROW_CYC(ROW_CYC),
    .PART_LIMIT(PART_LIMIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wpN(wpN), .ioIn(ioIn),
    .beDone(beDone), .beFail(beFail), .addrLast(addrLast), .progOk(progOk),
    .busy(busy), .ioOut(ioOut), .opValid(opValid), .opKind(kindInt),
    .opCol(opCol), .opRow(opRow), .opRowAlt(opRowAlt), .opDual(opDual),
    .opAbort(opAbort), .wrValid(wrValid), .wrByte(wrByte)
  );

  assign opKind = kindInt;
  assign rbLow  = busy;

endmodule

// File: rtl/nand_cmd_decoder_chk.sv
module nand_cmd_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wpN,
  input logic       rbLow,
  input logic       beDone,
  input logic       opValid,
  input logic [1:0] opKind,
  input logic       opDual,
  input logic       opAbort
);

  // a request always comes with the busy line pulled (R2)
  p_issue_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> rbLow);

  // done releases the busy line on the next cycle (R2)
  p_done_release_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rbLow && beDone) |=> !rbLow);

  // only an erase may be two-plane (R6)
  p_dual_erase_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opDual) |-> (opKind == 2'd3));

  // reset command leaves nothing outstanding (R9)
  p_abort_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    opAbort |-> (!rbLow && !opValid));

  // nothing new starts while busy (R10)
  p_busy_no_issue_r10: assert property (@(posedge clk) disable iff (!rstN)
    rbLow |=> !opValid);

  // program and erase need write protect released when confirmed (R11)
  p_wp_block_r11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind != 2'd1) |-> $past(wpN));

endmodule

bind nand_cmd_decoder nand_cmd_decoder_chk u_chk (
  .clk(clk), .rstN(rstN), .wpN(wpN), .rbLow(rbLow), .beDone(beDone),
  .opValid(opValid), .opKind(opKind), .opDual(opDual), .opAbort(opAbort)
);

// File: tb/sim_nand_cmd_decoder.sv
`timescale 1ns/1ps
module sim_nand_cmd_decoder;

  logic clk = 1'b0, rstN = 1'b0;
  logic ceN = 1'b0, cle = 1'b0, ale = 1'b0, weN = 1'b1, reN = 1'b1, wpN = 1'b1;
  logic [7:0] io = 8'h00;
  logic beDone = 1'b0, beFail = 1'b0;
  logic [7:0]  ioOut, wrByte;
  logic        rbLow, opValid, opDual, opAbort, wrValid;
  logic [1:0]  opKind;
  logic [11:0] opCol;
  logic [17:0] opRow, opRowAlt;

  int checks = 0, errors = 0;
  logic [50:0] expQ[$];
  string       tagQ[$];
  logic [7:0]  wrQ[$];

  always #2.5 clk = ~clk;

  nand_cmd_decoder u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cleIn(cle), .aleIn(ale), .weN(weN),
    .reN(reN), .wpN(wpN), .ioIn(io), .ioOut(ioOut), .rbLow(rbLow),
    .beDone(beDone), .beFail(beFail), .opValid(opValid), .opKind(opKind),
    .opCol(opCol), .opRow(opRow), .opRowAlt(opRowAlt), .opDual(opDual),
    .opAbort(opAbort), .wrValid(wrValid), .wrByte(wrByte)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busCycle(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); cle = c; ale = a; io = b; weN = 1'b0;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); cle = 1'b0; ale = 1'b0;
  endtask
  task automatic cmd(input logic [7:0] b);  busCycle(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b);  busCycle(1'b0, 1'b1, b); endtask
  task automatic dat(input logic [7:0] b);  busCycle(1'b0, 1'b0, b); endtask

  task automatic adr5(input logic [7:0] c1, c2, r1, r2, r3);
    adr(c1); adr(c2); adr(r1); adr(r2); adr(r3);
  endtask

  task automatic rdByte(output logic [7:0] v);
    @(negedge clk); reN = 1'b0;
    @(negedge clk); v = ioOut; reN = 1'b1;
    @(negedge clk);
  endtask

  task automatic status(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    cmd(8'h70); rdByte(v); check(tag, 64'(v), 64'(exp));
  endtask

  task automatic finishOp(input logic f);
    @(negedge clk); beDone = 1'b1; beFail = f;
    @(negedge clk); beDone = 1'b0; beFail = 1'b0;
  endtask

  // expected request; address fields follow R3
  task automatic expectOp(input string tag, input logic [1:0] k,
                          input logic [7:0] c1, c2, r1, r2, r3,
                          input logic [17:0] alt, input logic dual);
    logic [11:0] col;
    logic [17:0] row;
    col = {c2[3:0], c1};
    row = {r3[1:0], r2, r1};
    if (k == 2'd3) col = '0;
    expQ.push_back({k, col, row, dual ? alt : 18'd0, dual});
    tagQ.push_back(tag);
  endtask

  task automatic expectAbort(input string tag);
    expQ.push_back('0);
    tagQ.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (opValid || opAbort) begin
        logic [50:0] act;
        act = opAbort ? 51'd0
                      : {opKind, (opKind == 2'd3) ? 12'd0 : opCol, opRow,
                         opDual ? opRowAlt : 18'd0, opDual};
        if (expQ.size() == 0) begin
          check("unexpected request R13", 64'(act), 64'h7FFFFFFFFFFFF);
        end else begin
          check(tagQ.pop_front(), 64'(act), 64'(expQ.pop_front()));
        end
      end
      if (wrValid) begin
        if (wrQ.size() == 0) check("unexpected data byte R5", 64'(wrByte), 64'h1FF);
        else check("data byte R5", 64'(wrByte), 64'(wrQ.pop_front()));
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 rbLow after reset", 64'(rbLow), 0);
    status("R1 status after reset", 8'hC0);

    // R2, R3 read with high address bits dropped
    cmd(8'h00);
    adr5(8'h34, 8'hF5, 8'h11, 8'h22, 8'hFF);
    expectOp("R2 R3 read request", 2'd1, 8'h34, 8'hF5, 8'h11, 8'h22, 8'hFF, 0, 0);
    cmd(8'h30);
    check("R2 rbLow while busy", 64'(rbLow), 1);
    status("R7 status while busy", 8'h80);
    finishOp(1'b0);
    check("R2 rbLow released", 64'(rbLow), 0);

    // R4 read without leading 00h
    adr5(8'h01, 8'h00, 8'h05, 8'h00, 8'h00);
    expectOp("R4 consecutive read", 2'd1, 8'h01, 8'h00, 8'h05, 8'h00, 8'h00, 0, 0);
    cmd(8'h30);
    finishOp(1'b0);

    // R5 program with status poll in the middle (R7)
    cmd(8'h80);
    adr5(8'h00, 8'h00, 8'h07, 8'h00, 8'h00);
    wrQ.push_back(8'hAA); dat(8'hAA);
    wrQ.push_back(8'h55); dat(8'h55);
    status("R7 status mid-sequence", 8'hC0);
    wrQ.push_back(8'h0F); dat(8'h0F);
    expectOp("R5 program request", 2'd2, 8'h00, 8'h00, 8'h07, 8'h00, 8'h00, 0, 0);
    cmd(8'h10);
    finishOp(1'b1);
    status("R7 fail bit after failed program", 8'hC1);

    // R6 single and two-plane erase
    cmd(8'h60); adr(8'h40); adr(8'h00); adr(8'h00);
    expectOp("R6 single erase", 2'd3, 0, 0, 8'h40, 8'h00, 8'h00, 0, 0);
    cmd(8'hD0);
    finishOp(1'b0);
    status("R7 fail bit cleared", 8'hC0);
    cmd(8'h60); adr(8'h80); adr(8'h00); adr(8'h00);
    cmd(8'h60); adr(8'hC0); adr(8'h00); adr(8'h00);
    expectOp("R6 two-plane erase", 2'd3, 0, 0, 8'hC0, 8'h00, 8'h00, 18'h80, 1);
    cmd(8'hD0);
    finishOp(1'b0);

    // R10 ignore while busy, R9 reset aborts
    cmd(8'h00); adr5(8'h00, 8'h00, 8'h01, 8'h00, 8'h00);
    expectOp("R10 read before busy test", 2'd1, 0, 0, 8'h01, 0, 0, 0, 0);
    cmd(8'h30);
    cmd(8'h60); adr(8'h10); adr(8'h00); adr(8'h00); cmd(8'hD0);
    check("R10 still busy", 64'(rbLow), 1);
    expectAbort("R9 abort while busy");
    cmd(8'hFF);
    check("R9 rbLow released by reset", 64'(rbLow), 0);
    cmd(8'h80); adr(8'h00); adr(8'h00);
    expectAbort("R9 abort mid-sequence");
    cmd(8'hFF);
    cmd(8'h10);
    check("R9 no request after abort", 64'(rbLow), 0);
    cmd(8'h60); adr(8'h20); adr(8'h00); adr(8'h00);
    expectOp("R9 idle after abort", 2'd3, 0, 0, 8'h20, 0, 0, 0, 0);
    cmd(8'hD0);
    finishOp(1'b0);

    // R8 identification bytes
    cmd(8'h90); adr(8'h00);
    rdByte(v); check("R8 id byte 0", 64'(v), 64'hEC);
    rdByte(v); check("R8 id byte 1", 64'(v), 64'hDC);
    rdByte(v); check("R8 id byte 2", 64'(v), 64'h10);
    rdByte(v); check("R8 id byte 3", 64'(v), 64'h95);

    // R11 write protect
    wpN = 1'b0;
    cmd(8'h80); adr5(8'h00, 8'h00, 8'h09, 8'h00, 8'h00);
    wrQ.push_back(8'h12); dat(8'h12);
    cmd(8'h10);
    check("R11 program blocked", 64'(rbLow), 0);
    status("R11 status protected", 8'h41);
    cmd(8'h60); adr(8'h09); adr(8'h00); adr(8'h00); cmd(8'hD0);
    check("R11 erase blocked", 64'(rbLow), 0);
    wpN = 1'b1;
    status("R11 status unprotected", 8'hC1);

    // R12 partial program budget
    for (int i = 0; i < 4; i++) begin
      cmd(8'h80); adr5(8'h00, 8'h00, 8'h09, 8'h00, 8'h00);
      expectOp("R12 main program within budget", 2'd2, 0, 0, 8'h09, 0, 0, 0, 0);
      cmd(8'h10);
      finishOp(1'b0);
    end
    cmd(8'h80); adr5(8'h00, 8'h00, 8'h09, 8'h00, 8'h00); cmd(8'h10);
    check("R12 fifth main program refused", 64'(rbLow), 0);
    status("R12 fail bit on refusal", 8'hC1);
    cmd(8'h80); adr5(8'h00, 8'h08, 8'h09, 8'h00, 8'h00);
    expectOp("R12 spare program separate budget", 2'd2, 8'h00, 8'h08, 8'h09, 0, 0, 0, 0);
    cmd(8'h10);
    finishOp(1'b0);
    cmd(8'h60); adr(8'h00); adr(8'h00); adr(8'h00);
    expectOp("R12 erase before refill", 2'd3, 0, 0, 0, 0, 0, 0, 0);
    cmd(8'hD0);
    finishOp(1'b0);
    cmd(8'h80); adr5(8'h00, 8'h00, 8'h09, 8'h00, 8'h00);
    expectOp("R12 budget restored by erase", 2'd2, 0, 0, 8'h09, 0, 0, 0, 0);
    cmd(8'h10);
    finishOp(1'b0);

    // R13 malformed sequences, shortcut disarmed
    cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03); cmd(8'h30);
    adr5(8'h01, 8'h00, 8'h02, 8'h00, 8'h00); cmd(8'h30);
    cmd(8'h60); adr(8'h05); adr(8'h00); cmd(8'hD0);
    cmd(8'h80); adr5(8'h00, 8'h00, 8'h03, 8'h00, 8'h00); adr(8'h00); cmd(8'h10);
    check("R13 nothing started", 64'(rbLow), 0);
    status("R13 status unchanged", 8'hC0);

    repeat (4) @(negedge clk);
    check("R13 all expected requests seen", 64'(expQ.size()), 0);
    check("R5 all data bytes seen", 64'(wrQ.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule